// File: doc/BRIEF.md
# Read-after-write interlock for an in-order five-stage pipeline

This block decides, every cycle, whether the instruction sitting in decode may move on to execute. The pipeline it guards has no operand bypassing, so a source register is only safe to read once every older instruction that writes that register has left the pipeline. The block compares both source fields of the decode instruction against the destination of each of the three later stages (execute, memory, write-back). A match on a stage that writes, on a source the instruction actually reads, raises `stall`.

To give the stall a concrete effect, the block carries a compact model of the pipeline registers from decode onward, each with a valid bit. A stall freezes the program counter (the fetch side must hold its offered instruction) and the decode register, and sends an empty slot into execute. The memory and write-back stages keep moving, so the blocking producer drains out and the stall clears by itself. The decode register has two actions, FLOW (load the offered fetch instruction and pass the current one to execute) and HOLD (keep the current instruction and pass a bubble). The action is HOLD exactly when `stall` is high, and FLOW otherwise.

Top module: `raw_interlock`

## Requirements
- R1: A valid decode instruction with its rs-use flag high and a nonzero rs raises `stall` combinationally when a valid, writing instruction in execute, memory or write-back has a destination equal to rs. A non-writing producer never stalls it.
- R2: The same rule applies to the rt field, gated by the rt-use flag.
- R3: A source with its use flag low never causes a stall. Neither does a source field equal to register 0, even with its use flag high.
- R4: Only flow dependences stall. If decode writes a register that an older instruction reads or writes, and none of its own sources matches a pending destination, there is no stall.
- R5: If the consumer follows its producer at a distance of 1, 2 or 3 instructions, the consumer stalls for 3, 2 or 1 cycles. At a distance of 4 or more it does not stall. When both sources wait on different producers, the count is the larger of the two.
- R6: While `stall` is high, the decode instruction is kept and the offered fetch instruction is not taken. A consumer at fetch position p that stalls s cycles shows up in write-back exactly once, after clock edge p+4+s, counting the first edge after reset as edge 1.
- R7: The clock edge that ends a stall cycle puts an invalid slot with its write flag low into execute. An invalid slot never causes a stall.
- R8: Memory and write-back advance on every edge whatever `stall` is. The instruction at fetch position 0 appears in write-back after edge 4, with its destination and write flag intact.
- R9: An active-low asynchronous reset empties decode and all later stages, so `stall`, `ex_vld` and `wb_vld` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_vld | input | 1 | Offered fetch instruction is real |
| fetch_rs | input | REG_W | First source register field |
| fetch_rs_use | input | 1 | Instruction reads the first source |
| fetch_rt | input | REG_W | Second source register field |
| fetch_rt_use | input | 1 | Instruction reads the second source |
| fetch_wr | input | 1 | Instruction writes a register |
| fetch_dst | input | REG_W | Destination register field |
| stall | output | 1 | Hold PC and decode, insert a bubble |
| ex_vld | output | 1 | Execute slot holds an instruction |
| ex_wr | output | 1 | Execute slot writes a register |
| ex_dst | output | REG_W | Execute slot destination |
| wb_vld | output | 1 | Write-back slot holds an instruction |
| wb_wr | output | 1 | Write-back slot writes a register |
| wb_dst | output | REG_W | Write-back slot destination |

## Verification
The bench sweeps producer-to-consumer distances 1 to 5, on either source slot, in six patterns: a true match, use flag low, register 0, a non-writing producer, a write-after-read and a write-after-write. It counts the stall cycles against the 4-minus-distance rule. If the write-back comparison were missing, distance 3 would get no stall and the count would come out one short. A detector that ignored the zero-register or use gating, or that treated name dependences as hazards, would stall where none is due. Each case also checks that the consumer reaches write-back once, at the edge the stall count predicts, and is followed by a nop. A decode register that dropped or duplicated the held instruction, or a bubble that carried the write flag, would move that arrival or repeat it. A double-producer case checks that the longer wait wins.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
    localparam int LATER_STAGES = 3;
    localparam int NUM_SRC      = 2;
    localparam int STG_EX       = 0;
    localparam int STG_MEM      = 1;
    localparam int STG_WB       = 2;

    typedef enum logic {
        ACT_FLOW = 1'b0,
        ACT_HOLD = 1'b1
    } dec_act_e;
endpackage

// File: rtl/ilk_src_match.sv
module ilk_src_match #(
    parameter int AW   = 5,
    parameter int NSTG = 3
) (
    input  logic [AW-1:0]      src,
    input  logic               src_use,
    input  logic [NSTG*AW-1:0] dst_flat,
    input  logic [NSTG-1:0]    wr_vec,
    output logic               hit
);
    logic [NSTG-1:0] per_stage;

    generate
        for (genvar g = 0; g < NSTG; g++) begin : g_cmp
            assign per_stage[g] = wr_vec[g] && (dst_flat[g*AW +: AW] == src);
        end
    endgenerate

    // register 0 is never a real dependence
    assign hit = src_use && (src != '0) && (|per_stage);
endmodule

// File: rtl/ilk_detect.sv
module ilk_detect #(
    parameter int AW   = 5,
    parameter int NSTG = 3,
    parameter int NSRC = 2
) (
    input  logic               slot_vld,
    input  logic [NSRC*AW-1:0] src_flat,
    input  logic [NSRC-1:0]    use_vec,
    input  logic [NSTG*AW-1:0] dst_flat,
    input  logic [NSTG-1:0]    wr_vec,
    output logic               stall
);
    logic [NSRC-1:0] src_hit;

    generate
        for (genvar k = 0; k < NSRC; k++) begin : g_src
            ilk_src_match #(.AW(AW), .NSTG(NSTG)) u_match (
                .src      (src_flat[k*AW +: AW]),
                .src_use  (use_vec[k]),
                .dst_flat (dst_flat),
                .wr_vec   (wr_vec),
                .hit      (src_hit[k])
            );
        end
    endgenerate

    assign stall = slot_vld && (|src_hit);
endmodule

// File: rtl/ilk_pipe.sv
module ilk_pipe #(
    parameter int AW   = 5,
    parameter int NSTG = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stall,
    input  logic               fetch_vld,
    input  logic [AW-1:0]      fetch_rs,
    input  logic               fetch_rs_use,
    input  logic [AW-1:0]      fetch_rt,
    input  logic               fetch_rt_use,
    input  logic               fetch_wr,
    input  logic [AW-1:0]      fetch_dst,
    output logic               dec_vld,
    output logic [AW-1:0]      dec_rs,
    output logic               dec_rs_use,
    output logic [AW-1:0]      dec_rt,
    output logic               dec_rt_use,
    output logic               dec_wr,
    output logic [AW-1:0]      dec_dst,
    output logic [NSTG-1:0]    stg_vld,
    output logic [NSTG-1:0]    stg_wr,
    output logic [NSTG*AW-1:0] stg_dst
);
    import ilk_pkg::*;

    dec_act_e    act;
    logic        ins_vld;
    logic        ins_wr;
    logic [AW-1:0] ins_dst;

    assign act = stall ? ACT_HOLD : ACT_FLOW;

    // decode register: loads on FLOW, keeps its instruction on HOLD
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_vld    <= 1'b0;
            dec_rs     <= '0;
            dec_rs_use <= 1'b0;
            dec_rt     <= '0;
            dec_rt_use <= 1'b0;
            dec_wr     <= 1'b0;
            dec_dst    <= '0;
        end else begin
            unique case (act)
                ACT_FLOW: begin
                    dec_vld    <= fetch_vld;
                    dec_rs     <= fetch_rs;
                    dec_rs_use <= fetch_rs_use;
                    dec_rt     <= fetch_rt;
                    dec_rt_use <= fetch_rt_use;
                    dec_wr     <= fetch_wr;
                    dec_dst    <= fetch_dst;
                end
                ACT_HOLD: begin
                    dec_vld    <= dec_vld;
                    dec_rs     <= dec_rs;
                    dec_rs_use <= dec_rs_use;
                    dec_rt     <= dec_rt;
                    dec_rt_use <= dec_rt_use;
                    dec_wr     <= dec_wr;
                    dec_dst    <= dec_dst;
                end
                default: begin
                    dec_vld    <= 1'b0;
                    dec_rs     <= '0;
                    dec_rs_use <= 1'b0;
                    dec_rt     <= '0;
                    dec_rt_use <= 1'b0;
                    dec_wr     <= 1'b0;
                    dec_dst    <= '0;
                end
            endcase
        end
    end

    // what enters execute: the decode instruction, or a bubble that writes nothing
    always_comb begin
        unique case (act)
            ACT_FLOW: begin
                ins_vld = dec_vld;
                ins_wr  = dec_vld && dec_wr;
                ins_dst = dec_dst;
            end
            ACT_HOLD: begin
                ins_vld = 1'b0;
                ins_wr  = 1'b0;
                ins_dst = '0;
            end
            default: begin
                ins_vld = 1'b0;
                ins_wr  = 1'b0;
                ins_dst = '0;
            end
        endcase
    end

    // later stages never stop
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_vld <= '0;
            stg_wr  <= '0;
            stg_dst <= '0;
        end else begin
            stg_vld[0]        <= ins_vld;
            stg_wr[0]         <= ins_wr;
            stg_dst[0 +: AW]  <= ins_dst;
            for (int g = 1; g < NSTG; g++) begin
                stg_vld[g]        <= stg_vld[g-1];
                stg_wr[g]         <= stg_wr[g-1];
                stg_dst[g*AW +: AW] <= stg_dst[(g-1)*AW +: AW];
            end
        end
    end
endmodule

// File: rtl/raw_interlock.sv
module raw_interlock #(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_vld,
    input  logic [REG_W-1:0] fetch_rs,
    input  logic             fetch_rs_use,
    input  logic [REG_W-1:0] fetch_rt,
    input  logic             fetch_rt_use,
    input  logic             fetch_wr,
    input  logic [REG_W-1:0] fetch_dst,
    output logic             stall,
    output logic             ex_vld,
    output logic             ex_wr,
    output logic [REG_W-1:0] ex_dst,
    output logic             wb_vld,
    output logic             wb_wr,
    output logic [REG_W-1:0] wb_dst
);
    import ilk_pkg::*;

    localparam int NSTG = LATER_STAGES;

    logic             dec_vld;
    logic [REG_W-1:0] dec_rs;
    logic             dec_rs_use;
    logic [REG_W-1:0] dec_rt;
    logic             dec_rt_use;
    logic             dec_wr;
    logic [REG_W-1:0] dec_dst;
    logic [NSTG-1:0]       stg_vld;
    logic [NSTG-1:0]       stg_wr;
    logic [NSTG*REG_W-1:0] stg_dst;
    logic             mem_vld;
    logic             mem_wr;
    logic [REG_W-1:0] mem_dst;

    ilk_pipe #(.AW(REG_W), .NSTG(NSTG)) u_pipe (
        .clk          (clk),
        .rst_n        (rst_n),
        .stall        (stall),
        .fetch_vld    (fetch_vld),
        .fetch_rs     (fetch_rs),
        .fetch_rs_use (fetch_rs_use),
        .fetch_rt     (fetch_rt),
        .fetch_rt_use (fetch_rt_use),
        .fetch_wr     (fetch_wr),
        .fetch_dst    (fetch_dst),
        .dec_vld      (dec_vld),
        .dec_rs       (dec_rs),
        .dec_rs_use   (dec_rs_use),
        .dec_rt       (dec_rt),
        .dec_rt_use   (dec_rt_use),
        .dec_wr       (dec_wr),
        .dec_dst      (dec_dst),
        .stg_vld      (stg_vld),
        .stg_wr       (stg_wr),
        .stg_dst      (stg_dst)
    );

    ilk_detect #(.AW(REG_W), .NSTG(NSTG), .NSRC(NUM_SRC)) u_det (
        .slot_vld (dec_vld),
        .src_flat ({dec_rt, dec_rs}),
        .use_vec  ({dec_rt_use, dec_rs_use}),
        .dst_flat (stg_dst),
        .wr_vec   (stg_wr),
        .stall    (stall)
    );

    assign ex_vld  = stg_vld[STG_EX];
    assign ex_wr   = stg_wr[STG_EX];
    assign ex_dst  = stg_dst[STG_EX*REG_W +: REG_W];
    assign mem_vld = stg_vld[STG_MEM];
    assign mem_wr  = stg_wr[STG_MEM];
    assign mem_dst = stg_dst[STG_MEM*REG_W +: REG_W];
    assign wb_vld  = stg_vld[STG_WB];
    assign wb_wr   = stg_wr[STG_WB];
    assign wb_dst  = stg_dst[STG_WB*REG_W +: REG_W];
endmodule

// File: rtl/raw_interlock_chk.sv
module raw_interlock_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stall,
    input logic          dec_vld,
    input logic [AW-1:0] dec_rs,
    input logic          dec_rs_use,
    input logic [AW-1:0] dec_rt,
    input logic          dec_rt_use,
    input logic [AW-1:0] dec_dst,
    input logic          ex_vld,
    input logic          ex_wr,
    input logic [AW-1:0] ex_dst,
    input logic          mem_vld,
    input logic          mem_wr,
    input logic [AW-1:0] mem_dst,
    input logic          wb_vld,
    input logic          wb_wr,
    input logic [AW-1:0] wb_dst
);
    // R1
    ex_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && dec_rs_use && dec_rs != '0 && ex_wr && ex_dst == dec_rs) |-> stall);

    // R3
    zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!dec_rs_use || dec_rs == '0) && (!dec_rt_use || dec_rt == '0)) |-> !stall);

    // R4
    no_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_wr && !mem_wr && !wb_wr) |-> !stall);

    // R6
    hold_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (dec_vld && $stable(dec_rs) && $stable(dec_rt) && $stable(dec_dst)));

    // R7
    bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (!ex_vld && !ex_wr));

    // R7
    empty_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_vld |-> !stall);

    // R8
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_vld |=> (wb_vld && wb_dst == $past(mem_dst) && wb_wr == $past(mem_wr)));

    // R8
    drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_vld |=> !wb_vld);
endmodule

bind raw_interlock raw_interlock_chk #(.AW(REG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall      (stall),
    .dec_vld    (dec_vld),
    .dec_rs     (dec_rs),
    .dec_rs_use (dec_rs_use),
    .dec_rt     (dec_rt),
    .dec_rt_use (dec_rt_use),
    .dec_dst    (dec_dst),
    .ex_vld     (ex_vld),
    .ex_wr      (ex_wr),
    .ex_dst     (ex_dst),
    .mem_vld    (mem_vld),
    .mem_wr     (mem_wr),
    .mem_dst    (mem_dst),
    .wb_vld     (wb_vld),
    .wb_wr      (wb_wr),
    .wb_dst     (wb_dst)
);

// File: tb/raw_interlock_test.sv
module raw_interlock_test;
    localparam int W = 5;

    typedef struct packed {
        logic         vld;
        logic [W-1:0] rs;
        logic         rsu;
        logic [W-1:0] rt;
        logic         rtu;
        logic         wr;
        logic [W-1:0] dst;
    } ins_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    ins_t         fin;
    logic         stall, ex_vld, ex_wr, wb_vld, wb_wr;
    logic [W-1:0] ex_dst, wb_dst;

    int total = 0;
    int bad = 0;
    ins_t prog [0:31];

    always #4 clk = ~clk;

    raw_interlock #(.REG_W(W)) uut (
        .clk(clk), .rst_n(rst_n),
        .fetch_vld(fin.vld), .fetch_rs(fin.rs), .fetch_rs_use(fin.rsu),
        .fetch_rt(fin.rt), .fetch_rt_use(fin.rtu), .fetch_wr(fin.wr),
        .fetch_dst(fin.dst),
        .stall(stall), .ex_vld(ex_vld), .ex_wr(ex_wr), .ex_dst(ex_dst),
        .wb_vld(wb_vld), .wb_wr(wb_wr), .wb_dst(wb_dst)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic ins_t nop_ins();
        ins_t n;
        n = '0;
        n.vld = 1'b1;
        return n;
    endfunction

    // runs prog[]; consumer at position cp, expected stall cycles exp_s
    task automatic run_prog(input int cp, input int exp_s, input string tag);
        int pc;
        int stalls;
        bit prev_s;
        rst_n = 1'b0;
        fin = prog[0];
        @(negedge clk);
        @(negedge clk);
        check(!stall && !ex_vld && !wb_vld, "R9 reset state", {stall, ex_vld, wb_vld}, 0);
        rst_n = 1'b1;
        pc = 0;
        stalls = 0;
        prev_s = 1'b0;
        for (int e = 1; e <= cp + 12; e++) begin
            @(posedge clk);
            @(negedge clk);
            if (!prev_s) pc++;
            fin = prog[pc];
            if (prev_s)
                check(!ex_vld && !ex_wr, "R7 bubble after stall", {ex_vld, ex_wr}, 0);
            if (e == 4)
                check(wb_vld && wb_wr == prog[0].wr && wb_dst == prog[0].dst,
                      "R8 producer drained to write-back", int'(wb_dst), int'(prog[0].dst));
            if (e == cp + 4 + exp_s)
                check(wb_vld && wb_wr && wb_dst == prog[cp].dst,
                      "R6 held consumer retires once", int'(wb_dst), int'(prog[cp].dst));
            if (e == cp + 5 + exp_s)
                check(wb_vld && !wb_wr, "R6 no duplicate after consumer", int'(wb_wr), 0);
            stalls += int'(stall);
            prev_s = stall;
        end
        check(stalls == exp_s, tag, stalls, exp_s);
    endtask

    initial begin
        #1000000;
        bad++;
        total++;
        $display("FAIL R9 watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        ins_t prod, cons;
        fin = nop_ins();
        for (int d = 1; d <= 5; d++) begin
            for (int slot = 0; slot < 2; slot++) begin
                for (int v = 0; v < 6; v++) begin
                    int exp_s;
                    string tag;
                    for (int i = 0; i < 32; i++) prog[i] = nop_ins();
                    prod = '{vld:1'b1, rs:5'd1, rsu:1'b1, rt:5'd2, rtu:1'b1, wr:1'b1, dst:5'd7};
                    cons = '{vld:1'b1, rs:5'd4, rsu:1'b1, rt:5'd4, rtu:1'b1, wr:1'b1, dst:5'd12};
                    exp_s = 0;
                    case (v)
                        0: begin // true flow dependence
                            if (slot == 0) cons.rs = 5'd7; else cons.rt = 5'd7;
                            exp_s = (d < 4) ? 4 - d : 0;
                            tag = (slot == 0) ? "R1 R5 rs match stall count" : "R2 R5 rt match stall count";
                        end
                        1: begin // use flag low
                            if (slot == 0) begin cons.rs = 5'd7; cons.rsu = 1'b0; end
                            else begin cons.rt = 5'd7; cons.rtu = 1'b0; end
                            tag = "R3 use flag low no stall";
                        end
                        2: begin // register 0
                            prod.dst = 5'd0;
                            if (slot == 0) cons.rs = 5'd0; else cons.rt = 5'd0;
                            tag = "R3 register 0 no stall";
                        end
                        3: begin // producer does not write
                            prod.wr = 1'b0;
                            if (slot == 0) cons.rs = 5'd7; else cons.rt = 5'd7;
                            tag = "R1 non-writing producer no stall";
                        end
                        4: begin // write after read
                            prod.dst = 5'd9;
                            if (slot == 0) prod.rs = 5'd7; else prod.rt = 5'd7;
                            cons.rs = 5'd3; cons.rt = 5'd4; cons.dst = 5'd7;
                            tag = "R4 anti dependence no stall";
                        end
                        default: begin // write after write
                            cons.rs = 5'd3; cons.rt = 5'd4; cons.dst = 5'd7;
                            tag = "R4 output dependence no stall";
                        end
                    endcase
                    prog[0] = prod;
                    prog[d] = cons;
                    run_prog(d, exp_s, tag);
                end
            end
        end

        // two producers at distances 2 and 1: longer wait wins
        for (int i = 0; i < 32; i++) prog[i] = nop_ins();
        prog[0] = '{vld:1'b1, rs:5'd1, rsu:1'b1, rt:5'd2, rtu:1'b0, wr:1'b1, dst:5'd5};
        prog[1] = '{vld:1'b1, rs:5'd1, rsu:1'b1, rt:5'd2, rtu:1'b0, wr:1'b1, dst:5'd6};
        prog[2] = '{vld:1'b1, rs:5'd5, rsu:1'b1, rt:5'd6, rtu:1'b1, wr:1'b1, dst:5'd11};
        run_prog(2, 3, "R5 two producers max stall");

        // two producers at distances 3 and 2, sources swapped
        for (int i = 0; i < 32; i++) prog[i] = nop_ins();
        prog[0] = '{vld:1'b1, rs:5'd1, rsu:1'b0, rt:5'd2, rtu:1'b0, wr:1'b1, dst:5'd8};
        prog[1] = '{vld:1'b1, rs:5'd1, rsu:1'b0, rt:5'd2, rtu:1'b0, wr:1'b1, dst:5'd10};
        prog[3] = '{vld:1'b1, rs:5'd10, rsu:1'b1, rt:5'd8, rtu:1'b1, wr:1'b1, dst:5'd13};
        run_prog(3, 2, "R5 two producers swapped sources");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule